// File: doc/BRIEF.md
# Paired-Driver Select Decoder with Switch Latch

This block turns a word address into the driver enables of a coincident-current matrix in which every X and Y line sits between one top driver and one bottom driver. With the default sizing there are 64 X lines and 32 Y lines. Pairing the drivers cuts the count to 8+8 for X and 8+4 for Y, which is 28 enables in total. Each line is chosen by a unique top/bottom pair. Both drivers of that pair fire together, and a polarity flag tells the analog side which way the current flows. When both drivers of a line reverse polarity, the current in that same line reverses.

The block also models the switching-core latch found in each current switch. A set strobe starts the read phase. It decodes the address, fires the chosen drivers with read polarity, and records in a per-driver flip bit which drivers fired. A reset strobe starts the write phase. It fires, with write polarity, exactly those drivers whose flip bit is set, then clears every flip bit. The address bus plays no part in this phase. The upper select group uses an effective field: the sum of the two high address bits and a bank value, truncated to the group's width. A line-index output reports the selected X and Y line numbers.

Top module: `select_pair_decoder`

## Requirements
- R1: One cycle after a set strobe, `xb_en` is one-hot at position addr[2:0].
- R2: One cycle after a set strobe, `xt_en` is one-hot at position addr[5:3].
- R3: One cycle after a set strobe, `yb_en` is one-hot at position addr[7:6].
- R4: One cycle after a set strobe, `yt_en` is one-hot at position (addr[9:8] + bank) mod 8. The two high bits are zero-extended before the sum.
- R5: A set strobe drives enables with `write_pol` = 0 (read) for exactly one cycle. The enables appear on the cycle after the clock edge that samples the strobe.
- R6: A reset strobe that follows a set fires, one cycle later, the same drivers that the set fired, with `write_pol` = 1. This holds whatever `addr` and `bank` hold when the reset strobe arrives.
- R7: A reset strobe with no set since the last reset strobe, or since the last device reset, gives all enables 0.
- R8: In a cycle after a clock edge that saw neither strobe, all enables are 0 and `line_valid` is 0.
- R9: While `line_valid` is 1, `x_line` = 8*index(xt_en) + index(xb_en) and `y_line` = 4*index(yt_en) + index(yb_en). Every one of the 2048 (address, upper-field) combinations maps to a distinct (x_line, y_line) pair.
- R10: When the set and reset strobes are both high, the set wins. The outputs show read polarity with the new decode, and the flip bits are loaded.
- R11: While `rst_n` is low, and after it rises, all enables, `write_pol` and `line_valid` are 0, and all flip bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 10 | Word address bits below the upper field |
| bank | input | 3 | Bank value added to addr[9:8] |
| set_strobe | input | 1 | Read phase: decode and flip the chosen drivers |
| reset_strobe | input | 1 | Write phase: fire the flipped drivers back |
| xt_en | output | 8 | X top driver enables |
| xb_en | output | 8 | X bottom driver enables |
| yt_en | output | 8 | Y top driver enables |
| yb_en | output | 4 | Y bottom driver enables |
| write_pol | output | 1 | 0 = read current direction, 1 = write direction |
| x_line | output | 6 | Selected X line index |
| y_line | output | 5 | Selected Y line index |
| line_valid | output | 1 | Every driver group is exactly one-hot |

## Verification
The hardest case is to show that the write phase uses the latched flip bits and not the bus. The reset strobe on its own looks the same as a decode unless the address changes in between. For that reason, every address in the sweep is followed by a reset strobe with `addr` bit-inverted and `bank` changed, and the write-phase enables must still match the read-phase ones. Separate sequences cover two more cases: a reset strobe straight after device reset, and a second reset strobe with no set in between. Both show that the flip bits are empty or cleared. The uniqueness of the line pairs is checked over the whole 2048-entry space by sweeping all addresses at bank 0 and at bank 4, which covers all eight upper-field values.

// File: rtl/spd_pkg.sv
package spd_pkg;

   typedef enum logic {
      POL_READ  = 1'b0,
      POL_WRITE = 1'b1
   } drive_pol_e;

endpackage

// File: rtl/spd_onehot_dec.sv
module spd_onehot_dec #(
   parameter int SEL_BITS = 3
) (
   input  logic [SEL_BITS-1:0]      sel_i,
   output logic [(1<<SEL_BITS)-1:0] oh_o
);
   localparam int NOUT = 1 << SEL_BITS;

   for (genvar g = 0; g < NOUT; g++) begin : g_out
      assign oh_o[g] = (sel_i == SEL_BITS'(g));
   end
endmodule

// File: rtl/spd_switch_bank.sv
// One switching element per driver: the set strobe loads the flip bit from
// the decode, the reset strobe fires back exactly the flipped elements.
module spd_switch_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [N-1:0] dec_i,
   output logic [N-1:0] en_o
);
   for (genvar g = 0; g < N; g++) begin : g_sw
      logic flip_q;
      logic en_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flip_q <= 1'b0;
            en_q   <= 1'b0;
         end else if (set_i) begin
            flip_q <= dec_i[g];
            en_q   <= dec_i[g];
         end else if (clr_i) begin
            en_q   <= flip_q;
            flip_q <= 1'b0;
         end else begin
            en_q   <= 1'b0;
         end
      end

      assign en_o[g] = en_q;
   end
endmodule

// File: rtl/spd_line_enc.sv
module spd_line_enc #(
   parameter int TOP_BITS = 3,
   parameter int BOT_BITS = 3
) (
   input  logic [(1<<TOP_BITS)-1:0]   top_oh,
   input  logic [(1<<BOT_BITS)-1:0]   bot_oh,
   output logic [TOP_BITS+BOT_BITS-1:0] idx_o,
   output logic                       valid_o
);
   localparam int NT = 1 << TOP_BITS;
   localparam int NB = 1 << BOT_BITS;

   logic [TOP_BITS-1:0] t_idx;
   logic [BOT_BITS-1:0] b_idx;
   logic                t_one;
   logic                b_one;

   always_comb begin
      t_idx = '0;
      for (int i = 0; i < NT; i++) begin
         if (top_oh[i]) t_idx = t_idx | TOP_BITS'(i);
      end
      b_idx = '0;
      for (int i = 0; i < NB; i++) begin
         if (bot_oh[i]) b_idx = b_idx | BOT_BITS'(i);
      end
   end

   assign t_one   = (top_oh != '0) && ((top_oh & (top_oh - NT'(1))) == '0);
   assign b_one   = (bot_oh != '0) && ((bot_oh & (bot_oh - NB'(1))) == '0);
   assign valid_o = t_one && b_one;
   assign idx_o   = valid_o ? {t_idx, b_idx} : '0;
endmodule

// File: rtl/select_pair_decoder.sv
module select_pair_decoder #(
   parameter int XB_BITS = 3,
   parameter int XT_BITS = 3,
   parameter int YB_BITS = 2,
   parameter int YT_BITS = 3,
   parameter int HI_BITS = 2,
   parameter int BANK_W  = 3,
   localparam int ADDR_W = XB_BITS + XT_BITS + YB_BITS + HI_BITS,
   localparam int XW     = XT_BITS + XB_BITS,
   localparam int YW     = YT_BITS + YB_BITS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [BANK_W-1:0]        bank,
   input  logic                     set_strobe,
   input  logic                     reset_strobe,
   output logic [(1<<XT_BITS)-1:0]  xt_en,
   output logic [(1<<XB_BITS)-1:0]  xb_en,
   output logic [(1<<YT_BITS)-1:0]  yt_en,
   output logic [(1<<YB_BITS)-1:0]  yb_en,
   output logic                     write_pol,
   output logic [XW-1:0]            x_line,
   output logic [YW-1:0]            y_line,
   output logic                     line_valid
);
   import spd_pkg::*;

   localparam int XB_LO = 0;
   localparam int XT_LO = XB_LO + XB_BITS;
   localparam int YB_LO = XT_LO + XT_BITS;
   localparam int HI_LO = YB_LO + YB_BITS;

   if (HI_BITS > YT_BITS) begin : g_bad_hi
      $error("upper address field wider than Y top select");
   end
   if (BANK_W < 1 || XB_BITS < 1 || XT_BITS < 1 || YB_BITS < 1) begin : g_bad_w
      $error("select widths must be positive");
   end

   // address fields
   logic [XB_BITS-1:0] f_xb;
   logic [XT_BITS-1:0] f_xt;
   logic [YB_BITS-1:0] f_yb;
   logic [YT_BITS-1:0] f_yt;

   assign f_xb = addr[XB_LO +: XB_BITS];
   assign f_xt = addr[XT_LO +: XT_BITS];
   assign f_yb = addr[YB_LO +: YB_BITS];
   assign f_yt = YT_BITS'(addr[HI_LO +: HI_BITS]) + YT_BITS'(bank);

   logic [(1<<XT_BITS)-1:0] d_xt;
   logic [(1<<XB_BITS)-1:0] d_xb;
   logic [(1<<YT_BITS)-1:0] d_yt;
   logic [(1<<YB_BITS)-1:0] d_yb;

   spd_onehot_dec #(.SEL_BITS(XB_BITS)) u_dec_xb (.sel_i(f_xb), .oh_o(d_xb));
   spd_onehot_dec #(.SEL_BITS(XT_BITS)) u_dec_xt (.sel_i(f_xt), .oh_o(d_xt));
   spd_onehot_dec #(.SEL_BITS(YB_BITS)) u_dec_yb (.sel_i(f_yb), .oh_o(d_yb));
   spd_onehot_dec #(.SEL_BITS(YT_BITS)) u_dec_yt (.sel_i(f_yt), .oh_o(d_yt));

   // set has priority over reset
   logic do_set;
   logic do_clr;
   assign do_set = set_strobe;
   assign do_clr = reset_strobe & ~set_strobe;

   spd_switch_bank #(.N(1<<XB_BITS)) u_sw_xb (
      .clk(clk), .rst_n(rst_n), .set_i(do_set), .clr_i(do_clr),
      .dec_i(d_xb), .en_o(xb_en));
   spd_switch_bank #(.N(1<<XT_BITS)) u_sw_xt (
      .clk(clk), .rst_n(rst_n), .set_i(do_set), .clr_i(do_clr),
      .dec_i(d_xt), .en_o(xt_en));
   spd_switch_bank #(.N(1<<YB_BITS)) u_sw_yb (
      .clk(clk), .rst_n(rst_n), .set_i(do_set), .clr_i(do_clr),
      .dec_i(d_yb), .en_o(yb_en));
   spd_switch_bank #(.N(1<<YT_BITS)) u_sw_yt (
      .clk(clk), .rst_n(rst_n), .set_i(do_set), .clr_i(do_clr),
      .dec_i(d_yt), .en_o(yt_en));

   drive_pol_e pol_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      pol_q <= POL_READ;
      else if (do_clr) pol_q <= POL_WRITE;
      else             pol_q <= POL_READ;
   end
   assign write_pol = (pol_q == POL_WRITE);

   logic x_ok;
   logic y_ok;

   spd_line_enc #(.TOP_BITS(XT_BITS), .BOT_BITS(XB_BITS)) u_enc_x (
      .top_oh(xt_en), .bot_oh(xb_en), .idx_o(x_line), .valid_o(x_ok));
   spd_line_enc #(.TOP_BITS(YT_BITS), .BOT_BITS(YB_BITS)) u_enc_y (
      .top_oh(yt_en), .bot_oh(yb_en), .idx_o(y_line), .valid_o(y_ok));

   assign line_valid = x_ok & y_ok;
endmodule

// File: rtl/select_pair_decoder_chk.sv
module select_pair_decoder_chk #(
   parameter int XB_BITS = 3,
   parameter int XT_BITS = 3,
   parameter int YB_BITS = 2,
   parameter int YT_BITS = 3,
   parameter int HI_BITS = 2,
   parameter int BANK_W  = 3,
   localparam int ADDR_W = XB_BITS + XT_BITS + YB_BITS + HI_BITS
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        addr,
   input logic                     set_strobe,
   input logic                     reset_strobe,
   input logic [(1<<XT_BITS)-1:0]  xt_en,
   input logic [(1<<XB_BITS)-1:0]  xb_en,
   input logic [(1<<YT_BITS)-1:0]  yt_en,
   input logic [(1<<YB_BITS)-1:0]  yb_en,
   input logic                     write_pol,
   input logic                     line_valid
);
   assert_onehot_groups_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xt_en) && $onehot0(xb_en) && $onehot0(yt_en) && $onehot0(yb_en));

   assert_set_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(set_strobe)) |->
         (!write_pol && line_valid && $countones(xt_en) == 1 &&
          $countones(xb_en) == 1 && $countones(yt_en) == 1 &&
          $countones(yb_en) == 1));

   assert_xb_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(set_strobe)) |->
         (xb_en == ((1 << XB_BITS)'(1) << $past(addr[XB_BITS-1:0]))));

   assert_reset_pol_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(reset_strobe && !set_strobe)) |-> write_pol);

   assert_replay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_strobe && !set_strobe && $past(rst_n) && $past(set_strobe)) |=>
         (xt_en == $past(xt_en) && xb_en == $past(xb_en) &&
          yt_en == $past(yt_en) && yb_en == $past(yb_en)));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(set_strobe || reset_strobe)) |->
         (xt_en == '0 && xb_en == '0 && yt_en == '0 && yb_en == '0 && !line_valid));

   assert_empty_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_strobe && !set_strobe && $past(rst_n) && $past(reset_strobe && !set_strobe)) |=>
         (xt_en == '0 && xb_en == '0 && yt_en == '0 && yb_en == '0));
endmodule

bind select_pair_decoder select_pair_decoder_chk #(
   .XB_BITS(XB_BITS), .XT_BITS(XT_BITS), .YB_BITS(YB_BITS),
   .YT_BITS(YT_BITS), .HI_BITS(HI_BITS), .BANK_W(BANK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .set_strobe(set_strobe),
   .reset_strobe(reset_strobe), .xt_en(xt_en), .xb_en(xb_en),
   .yt_en(yt_en), .yb_en(yb_en), .write_pol(write_pol),
   .line_valid(line_valid));

// File: tb/select_pair_decoder_bench.sv
module select_pair_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic [2:0]  bank = '0;
   logic        set_strobe = 1'b0;
   logic        reset_strobe = 1'b0;
   logic [7:0]  xt_en, xb_en, yt_en;
   logic [3:0]  yb_en;
   logic        write_pol, line_valid;
   logic [5:0]  x_line;
   logic [4:0]  y_line;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit seen [2048];

   always #4 clk = ~clk;

   select_pair_decoder u_select_pair_decoder (
      .clk(clk), .rst_n(rst_n), .addr(addr), .bank(bank),
      .set_strobe(set_strobe), .reset_strobe(reset_strobe),
      .xt_en(xt_en), .xb_en(xb_en), .yt_en(yt_en), .yb_en(yb_en),
      .write_pol(write_pol), .x_line(x_line), .y_line(y_line),
      .line_valid(line_valid));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_zero(input string req);
      chk(xt_en == 0, req, "xt_en zero", xt_en, 0);
      chk(xb_en == 0, req, "xb_en zero", xb_en, 0);
      chk(yt_en == 0, req, "yt_en zero", yt_en, 0);
      chk(yb_en == 0, req, "yb_en zero", yb_en, 0);
      chk(line_valid == 0, req, "line_valid zero", line_valid, 0);
   endtask

   // compare all enables to an expected decode; pol is the expected polarity
   task automatic chk_sel(input int a, input int b, input bit pol, input string tag);
      int exb = a & 7;
      int ext = (a >> 3) & 7;
      int eyb = (a >> 6) & 3;
      int eyt = (((a >> 8) & 3) + b) & 7;
      chk(xb_en == 8'(1 << exb), "R1", {tag, " xb_en"}, xb_en, 1 << exb);
      chk(xt_en == 8'(1 << ext), "R2", {tag, " xt_en"}, xt_en, 1 << ext);
      chk(yb_en == 4'(1 << eyb), "R3", {tag, " yb_en"}, yb_en, 1 << eyb);
      chk(yt_en == 8'(1 << eyt), "R4", {tag, " yt_en"}, yt_en, 1 << eyt);
      chk(write_pol == pol, pol ? "R6" : "R5", {tag, " polarity"}, write_pol, pol);
      chk(line_valid == 1, "R9", {tag, " line_valid"}, line_valid, 1);
      chk(x_line == 6'(8 * ext + exb), "R9", {tag, " x_line"}, x_line, 8 * ext + exb);
      chk(y_line == 5'(4 * eyt + eyb), "R9", {tag, " y_line"}, y_line, 4 * eyt + eyb);
   endtask

   // set at one address, then replay with a scrambled bus
   task automatic cycle_pair(input int a, input int b, input bit mark);
      @(negedge clk);
      addr = 10'(a); bank = 3'(b); set_strobe = 1;
      @(negedge clk);
      set_strobe = 0;
      chk_sel(a, b, 1'b0, "read");
      if (mark) begin
         int key = 32 * x_line + y_line;
         chk(!seen[key], "R9", "unique line pair", key, -1);
         seen[key] = 1;
      end
      addr = ~10'(a); bank = 3'(b + 3); reset_strobe = 1;
      @(negedge clk);
      reset_strobe = 0;
      chk_sel(a, b, 1'b1, "write R6");
      @(negedge clk);
      chk_zero("R8");
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      chk_zero("R11");
      chk(write_pol == 0, "R11", "write_pol in reset", write_pol, 0);
      // keep a strobe high during reset: must still show nothing
      set_strobe = 1; addr = 10'h155;
      @(negedge clk);
      set_strobe = 0;
      chk_zero("R11");
      rst_n = 1;
      @(negedge clk);
      chk_zero("R11");
      // R7/R11: reset strobe right after device reset finds no flip bits
      reset_strobe = 1;
      @(negedge clk);
      reset_strobe = 0;
      chk_zero("R7");
      chk(write_pol == 1, "R6", "empty write polarity", write_pol, 1);

      // R7: a second reset after a set/reset pair finds the flip bits cleared
      @(negedge clk);
      addr = 10'h2a7; bank = 3'd1; set_strobe = 1;
      @(negedge clk);
      set_strobe = 0; reset_strobe = 1;
      @(negedge clk);
      chk_sel(10'h2a7, 1, 1'b1, "R6 first replay");
      @(negedge clk);
      reset_strobe = 0;
      chk_zero("R7");

      // R5: read enables last exactly one cycle
      @(negedge clk);
      addr = 10'h0f3; bank = 3'd2; set_strobe = 1;
      @(negedge clk);
      set_strobe = 0;
      chk_sel(10'h0f3, 2, 1'b0, "R5 read");
      @(negedge clk);
      chk_zero("R5");

      // R10: both strobes together -> set wins, then replay reflects it
      @(negedge clk);
      addr = 10'h3c9; bank = 3'd5; set_strobe = 1; reset_strobe = 1;
      @(negedge clk);
      set_strobe = 0; reset_strobe = 0;
      chk_sel(10'h3c9, 5, 1'b0, "R10 both");
      @(negedge clk);
      addr = 10'h000; bank = 3'd0; reset_strobe = 1;
      @(negedge clk);
      reset_strobe = 0;
      chk_sel(10'h3c9, 5, 1'b1, "R10 replay");

      // R4: every bank with every upper field value, incl. wrap-around
      for (int b = 0; b < 8; b++) begin
         for (int h = 0; h < 4; h++) begin
            cycle_pair((h << 8) | (b * 37 % 256), b, 1'b0);
         end
      end

      // R9: exhaustive sweep, banks 0 and 4 cover all 8 upper values
      foreach (seen[i]) seen[i] = 0;
      for (int bi = 0; bi < 2; bi++) begin
         for (int a = 0; a < 1024; a++) begin
            cycle_pair(a, bi * 4, 1'b1);
         end
      end
      begin
         int cnt = 0;
         foreach (seen[i]) if (seen[i]) cnt++;
         chk(cnt == 2048, "R9", "distinct line pairs", cnt, 2048);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule